// File: doc/BRIEF.md
# Page Table Walk Translation Unit

This block turns a 32-bit virtual address into a physical address using a single-level page table held in ordinary memory. A client presents a virtual address with an access kind (read, write or execute). The unit first compares the virtual page number against the current process's limit. It then fetches the 4-byte table entry through a simple request/ready memory port and checks the valid and permission bits. It returns either the physical address or a fault code.

Pages are 4 KB, so the low 12 address bits pass straight through and the upper 20 bits select the entry. On a successful access the unit keeps the entry's bookkeeping bits current in memory. It sets the reference bit on every successful access, and it also sets the dirty bit on a successful write. It writes the entry back once, before responding, and only when one of those bits actually changes.

The table base and the limit belong to the running process. They are loaded through a separate context port, which stands for a context switch. That port refuses a load while a walk is under way. Only one translation is outstanding at a time.

Top module: `pt_walk_top`

## Requirements
- R1: A successful translation responds with fault code 0 and physical address {entry[31:12], vaddr[11:0]}.
- R2: The entry is read with mem_we low at address base + vpn*4, where vpn is vaddr[31:12].
- R3: When vpn is greater than the limit, the response carries fault code 1 and the memory port is never requested; vpn equal to the limit is translated normally.
- R4: An entry whose bit 0 (valid) is clear gives fault code 2, and no write-back is made.
- R5: The access kind is encoded as 0 read, 1 write and 2 execute, and is permitted by entry bits 1, 2 and 3 respectively; kind 3 is never permitted. A refused kind gives fault code 3, and no write-back is made.
- R6: A successful access sets bit 4 (reference), and a successful write also sets bit 5 (dirty). The updated entry is written back to the same address exactly once, before the response, and only when its value changed; otherwise no write is issued.
- R7: ctx_load is accepted (ctx_load_ok high) only while the unit is idle, and a refused load leaves the base and limit unchanged. After reset the base and the limit are both 0.
- R8: req_ready is high only when idle. rsp_valid is a one-cycle pulse, and req_ready is high again in the cycle after it. A memory request holds its address and direction until mem_ready.
- R9: A faulting response returns physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and taking a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| ctx_load | input | 1 | Load a new table base and limit |
| ctx_base | input | 32 | Page table base byte address |
| ctx_limit | input | 20 | Highest allowed virtual page number |
| ctx_load_ok | output | 1 | Context load accepted this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Entry read data, valid with mem_ready |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 not valid, 3 protection |

## Verification
The main function is exercised with a repeated read and then a repeated write to the same page. This separates the first-touch write-backs that set the reference and dirty bits from the later accesses, which must leave memory alone. Each permission bit is tried against each access kind, and a missing entry is tried as well, so that fault 2 and fault 3 can be told apart. The limit is probed exactly at its value and one page above it, which shows whether the comparison is off by one. The walk is repeated with memory latencies of zero, one and three wait cycles, and with a context load attempted in the middle of a walk. These runs show whether the request is held steady and whether the refused load really left the base in place.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ_PTE, ST_WRITE_PTE, ST_RESPOND
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_LIMIT = 2'd1, FLT_INVALID = 2'd2, FLT_PROT = 2'd3
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int PTE_V     = 0;
  localparam int PTE_R     = 1;
  localparam int PTE_W     = 2;
  localparam int PTE_X     = 3;
  localparam int PTE_REF   = 4;
  localparam int PTE_DIRTY = 5;

  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/pt_walk_ctx.sv
module pt_walk_ctx #(
  parameter int ADDR_W = 32,
  parameter int VPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VPN_W-1:0]  limit_i,
  input  logic              idle_i,
  output logic              load_ok_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [VPN_W-1:0]  limit_o
);
  logic [ADDR_W-1:0] base_q;
  logic [VPN_W-1:0]  limit_q;

  always_comb load_ok_o = load_i & idle_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (load_ok_o) begin
      base_q  <= base_i;
      limit_q <= limit_i;
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;

  // R7: while a walk runs the context cannot move
  p_ctx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(base_o) && $stable(limit_o));
endmodule

// File: rtl/pt_walk_pte_eval.sv
module pt_walk_pte_eval import pt_walk_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pte_i,
  input  logic [1:0]        kind_i,
  output fault_e            fault_o,
  output logic [ADDR_W-1:0] pte_o,
  output logic              wb_o
);
  logic allowed;

  always_comb begin
    unique case (kind_i)
      ACC_READ:  allowed = pte_i[PTE_R];
      ACC_WRITE: allowed = pte_i[PTE_W];
      ACC_EXEC:  allowed = pte_i[PTE_X];
      default:   allowed = 1'b0;
    endcase

    if (!pte_i[PTE_V])   fault_o = FLT_INVALID;
    else if (!allowed)   fault_o = FLT_PROT;
    else                 fault_o = FLT_NONE;

    pte_o = pte_i;
    pte_o[PTE_REF] = 1'b1;
    if (kind_i == ACC_WRITE) pte_o[PTE_DIRTY] = 1'b1;

    wb_o = (fault_o == FLT_NONE) && (pte_o != pte_i);
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm import pt_walk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_vaddr_i,
  input  logic [1:0]              req_kind_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-OFF_W-1:0] limit_i,
  input  fault_e                  eval_fault_i,
  input  logic [ADDR_W-1:0]       eval_pte_i,
  input  logic                    eval_wb_i,
  input  logic                    mem_ready_i,
  output logic [1:0]              kind_o,
  output logic                    idle_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [ADDR_W-1:0]       mem_wdata_o,
  output logic                    rsp_valid_o,
  output logic [ADDR_W-1:0]       rsp_paddr_o,
  output logic [1:0]              rsp_fault_o
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int PAD_W = OFF_W - ENTRY_SHIFT;

  walk_state_e       state_q, state_d;
  fault_e            fault_q, fault_d;
  logic [ADDR_W-1:0] vaddr_q;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] pte_q;
  logic              cap_req, cap_pte;
  logic [VPN_W-1:0]  vpn;
  logic              over_limit;

  assign vpn        = vaddr_q[ADDR_W-1:OFF_W];
  assign over_limit = vpn > limit_i;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    cap_req = 1'b0;
    cap_pte = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cap_req = 1'b1;
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        fault_d = over_limit ? FLT_LIMIT : FLT_NONE;
        state_d = over_limit ? ST_RESPOND : ST_READ_PTE;
      end
      ST_READ_PTE: if (mem_ready_i) begin
        cap_pte = 1'b1;
        fault_d = eval_fault_i;
        state_d = eval_wb_i ? ST_WRITE_PTE : ST_RESPOND;
      end
      ST_WRITE_PTE: if (mem_ready_i) state_d = ST_RESPOND;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      vaddr_q <= '0;
      kind_q  <= '0;
      pte_q   <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      if (cap_req) begin
        vaddr_q <= req_vaddr_i;
        kind_q  <= req_kind_i;
      end
      if (cap_pte) pte_q <= eval_pte_i;
    end
  end

  assign kind_o      = kind_q;
  assign idle_o      = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_READ_PTE) || (state_q == ST_WRITE_PTE);
  assign mem_we_o    = (state_q == ST_WRITE_PTE);
  assign mem_addr_o  = base_i + {{PAD_W{1'b0}}, vpn, {ENTRY_SHIFT{1'b0}}};
  assign mem_wdata_o = pte_q;
  assign rsp_valid_o = (state_q == ST_RESPOND);
  assign rsp_fault_o = fault_q;
  assign rsp_paddr_o = (fault_q == FLT_NONE) ?
                       {pte_q[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;

  // R3: memory is only touched for pages inside the limit
  p_limit_nomem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !over_limit);
  // R6: every write-back carries a valid entry with the reference bit set
  p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[PTE_REF] && mem_wdata_o[PTE_V]));
  // R4 / R5: no write-back after a faulting lookup
  p_wb_no_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (fault_q == FLT_NONE));
  // R8: request held stable until memory takes it
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R8: response is a single pulse followed by readiness
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> (idle_o && !rsp_valid_o));
  // R9: faulting responses carry no address
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_paddr_o == '0));
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top import pt_walk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  localparam int VPN_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              ctx_load,
  input  logic [ADDR_W-1:0] ctx_base,
  input  logic [VPN_W-1:0]  ctx_limit,
  output logic              ctx_load_ok,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);
  logic              idle;
  logic [ADDR_W-1:0] base;
  logic [VPN_W-1:0]  limit;
  logic [1:0]        kind;
  fault_e            eval_fault;
  logic [ADDR_W-1:0] eval_pte;
  logic              eval_wb;

  pt_walk_ctx #(.ADDR_W(ADDR_W), .VPN_W(VPN_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .load_i(ctx_load), .base_i(ctx_base),
    .limit_i(ctx_limit), .idle_i(idle), .load_ok_o(ctx_load_ok),
    .base_o(base), .limit_o(limit)
  );

  pt_walk_pte_eval #(.ADDR_W(ADDR_W)) u_eval (
    .pte_i(mem_rdata), .kind_i(kind), .fault_o(eval_fault),
    .pte_o(eval_pte), .wb_o(eval_wb)
  );

  pt_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_kind_i(req_kind), .base_i(base), .limit_i(limit),
    .eval_fault_i(eval_fault), .eval_pte_i(eval_pte), .eval_wb_i(eval_wb),
    .mem_ready_i(mem_ready), .kind_o(kind), .idle_o(idle),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault)
  );

  assign req_ready = idle;
endmodule

// File: tb/sim_pt_walk_top.sv
`timescale 1ns/1ps
module sim_pt_walk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        ctx_load = 1'b0;
  logic [31:0] ctx_base = '0;
  logic [19:0] ctx_limit = '0;
  logic        ctx_load_ok;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  pt_walk_top u0 (.*);

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] m_base = '0;
  logic [19:0] m_limit = '0;
  int lat = 0, wait_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: decides after each edge, stable well before the next
  always @(posedge clk) begin
    #1;
    if (!rst_n || !mem_req) begin
      mem_ready = 1'b0;
      wait_cnt = 0;
    end else if (wait_cnt >= lat) begin
      mem_ready = 1'b1;
      wait_cnt = 0;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wr_addr = mem_addr;
        last_wr_data = mem_wdata;
      end else begin
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_cnt++;
        last_rd_addr = mem_addr;
      end
    end else begin
      mem_ready = 1'b0;
      wait_cnt++;
    end
  end

  task automatic load_ctx(input logic [31:0] b, input logic [19:0] l, input bit exp_ok);
    ctx_load = 1'b1; ctx_base = b; ctx_limit = l;
    #1;
    chk(ctx_load_ok == exp_ok, "R7", "ctx_load_ok", {31'd0, ctx_load_ok}, {31'd0, exp_ok});
    if (exp_ok) begin m_base = b; m_limit = l; end
    @(negedge clk);
    ctx_load = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] kind);
    logic [19:0] vpn;
    logic [31:0] ea, pte, npte, exp_pa;
    int f, rd0, wr0, n;
    bit wb, ok, bad_ready;
    string tag;
    vpn = va[31:12];
    ea = m_base + {10'd0, vpn, 2'b00};
    pte = mem.exists(ea) ? mem[ea] : 32'h0;
    npte = pte | 32'h10 | ((kind == 2'd1) ? 32'h20 : 32'h0);
    wb = 0;
    if (vpn > m_limit) f = 1;
    else if (!pte[0]) f = 2;
    else begin
      case (kind)
        2'd0: ok = pte[1];
        2'd1: ok = pte[2];
        2'd2: ok = pte[3];
        default: ok = 0;
      endcase
      f = ok ? 0 : 3;
      wb = ok && (npte != pte);
    end
    exp_pa = (f == 0) ? {pte[31:12], va[11:0]} : 32'h0;
    tag = (f == 0) ? "R1" : (f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
    rd0 = rd_cnt; wr0 = wr_cnt;
    chk(req_ready == 1'b1, "R8", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; bad_ready = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) bad_ready = 1;
      @(negedge clk);
      n++;
    end
    if (req_ready) bad_ready = 1;
    if (!rsp_valid) begin
      chk(0, "R8", "response timeout", 32'd0, 32'd1);
      return;
    end
    chk(!bad_ready, "R8", "ready low while busy", {31'd0, bad_ready}, 32'd0);
    chk(rsp_fault == f[1:0], tag, "fault code", {30'd0, rsp_fault}, f);
    chk(rsp_paddr == exp_pa, (f == 0) ? "R1" : "R9", "paddr", rsp_paddr, exp_pa);
    chk(rd_cnt - rd0 == ((f == 1) ? 0 : 1), (f == 1) ? "R3" : "R2", "read count",
        rd_cnt - rd0, (f == 1) ? 0 : 1);
    if (f != 1)
      chk(last_rd_addr == ea, "R2", "entry address", last_rd_addr, ea);
    chk(wr_cnt - wr0 == (wb ? 1 : 0), "R6", "write-back count", wr_cnt - wr0, wb ? 1 : 0);
    if (wb) begin
      chk(last_wr_addr == ea, "R6", "write-back address", last_wr_addr, ea);
      chk(last_wr_data == npte, "R6", "write-back data", last_wr_data, npte);
    end
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R8", "ready after response",
        {30'd0, req_ready, rsp_valid}, 32'd2);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // page table at 0x0001_0000
    mem[32'h0001_0000 + 4*5]  = 32'hABCDE_007;   // V R W
    mem[32'h0001_0000 + 4*6]  = 32'h11111_003;   // V R
    mem[32'h0001_0000 + 4*7]  = 32'h22222_009;   // V X
    mem[32'h0001_0000 + 4*9]  = 32'h33333_00E;   // R W X but not valid
    mem[32'h0001_0000 + 4*64] = 32'h44444_017;   // V R W, ref already set
    // second table at 0x0002_0000
    mem[32'h0002_0000 + 4*20'hFFFFF] = 32'h55555_00F;
    mem[32'h0002_0000 + 4*5]         = 32'h66666_003;

    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R8", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);

    // reset context: base 0, limit 0 -> page 1 over limit (R7, R3)
    walk(32'h0000_1000, 2'd0);

    load_ctx(32'h0001_0000, 20'h40, 1'b1);
    walk(32'h0000_5123, 2'd0);   // R1/R6 first read sets ref
    walk(32'h0000_5FFF, 2'd0);   // R6 no change, no write
    walk(32'h0000_5004, 2'd1);   // R6 first write sets dirty
    walk(32'h0000_5008, 2'd1);   // R6 nothing to change
    lat = 1;
    walk(32'h0000_6010, 2'd1);   // R5 write to read-only
    walk(32'h0000_6010, 2'd2);   // R5 exec denied
    walk(32'h0000_7ABC, 2'd2);   // R5 exec allowed
    walk(32'h0000_7ABC, 2'd3);   // R5 kind 3 always refused
    walk(32'h0000_8000, 2'd0);   // R4 missing entry
    walk(32'h0000_9000, 2'd0);   // R4 invalid despite permissions
    lat = 3;
    walk(32'h0004_0FED, 2'd0);   // R3 vpn equal to limit
    walk(32'h0004_1000, 2'd0);   // R3 one page beyond

    // R7 load attempt during a walk is refused
    fork
      walk(32'h0000_6444, 2'd0);
      begin
        @(negedge clk); @(negedge clk);
        load_ctx(32'h0002_0000, 20'hFFFFF, 1'b0);
      end
    join
    lat = 0;
    walk(32'h0000_5555, 2'd0);   // R7 still on the old table

    load_ctx(32'h0002_0000, 20'hFFFFF, 1'b1);
    walk(32'hFFFF_F321, 2'd1);   // top page of the new table
    walk(32'h0000_5abc, 2'd0);   // R7 new base used

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule